// File: doc/BRIEF.md
# Programmable Defect Condition Detector

This block watches eight tapped control signals and raises a flag whenever they take a programmed combination of values. The signals come from sources at different distances, so they reach the block with different latencies. Each input therefore first passes through its own programmable delay line. The signal that arrives latest is given no added delay. Every earlier signal is held back by the number of cycles between its own arrival and the latest one. After this step all inputs show values that belong to the same source cycle.

The aligned snapshot feeds a small sum-of-products array. Each product term has, for every input, one enable for the true literal and one for the complemented literal. Each condition output ORs a programmable subset of the product terms, and each output drives its own bit of a central defect register. All settings are loaded through a single register-write port. A global enable forces every flag low.

Top module: `cond_detect`

## Requirements
- R1: After reset, every flag is 0 and every setting (delays, term masks, OR masks) is 0. With these settings no flag rises for any input pattern.
- R2: With delay setting d (0 to 6) on input i, the array sees the value that `sig_i[i]` had d cycles earlier. A flag is registered: it rises one cycle after the aligned snapshot first meets its condition.
- R3: A delay setting above 6 (that is, 7) acts as a delay of 6.
- R4: A term mask word sets the true-literal enable for input i at bit i (bits 7:0) and the complemented-literal enable at bit 8+i (bits 15:8). A term is 1 only when every enabled literal holds. If a term enables both literals of the same input, it can never be 1.
- R5: A term with no literal enabled is 0 for every input pattern, even when an OR mask selects it.
- R6: Condition output o is the OR of the terms whose bit j is set in OR mask o, where bit j stands for term j.
- R7: A configuration write decodes `cfg_addr_i[4:3]` as the region: 0 selects a delay, taken from `wdata[2:0]`; 1 selects a term mask, taken from `wdata[15:0]`; 2 selects an OR mask, taken from `wdata[7:0]`. `cfg_addr_i[2:0]` is the index. Region 3 and OR-mask indices 4 to 7 change nothing.
- R8: A write changes the setting from the next cycle onward. The flag computed in the cycle of the write still uses the old setting.
- R9: While `en_i` is 0, the flags registered at that edge are 0. The delay lines keep shifting during this time, so flags are correct as soon as `en_i` returns to 1.
- R10: The outputs are independent. One term may feed several outputs, and several outputs may be high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable for the flags |
| sig_i | input | 8 | Tapped control signals |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration region and index |
| cfg_wdata_i | input | 16 | Configuration write data |
| flag_o | output | 4 | Registered condition flags |

## Verification
A wrong delay tap shows as a flag pulse that arrives one or more cycles too early or too late, or as a missed coincidence between inputs. It is visible within at most seven cycles after a single-input pulse. A wrong literal or OR-mask bit shows as a wrong flag for some input pattern on the very next edge, so the bench sweeps all 256 patterns against the programmed terms. A write that lands in the wrong place shows up as soon as the next sweep evaluates the affected term or output.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  localparam int N_IN    = 8;
  localparam int DLY_MAX = 6;
  localparam int N_TERM  = 8;
  localparam int N_OUT   = 4;

  typedef enum logic [1:0] {
    RG_DLY  = 2'd0,
    RG_TERM = 2'd1,
    RG_OR   = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  function automatic int idx_w(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/cdet_cfg.sv
module cdet_cfg #(
  parameter  int N_IN   = 8,
  parameter  int N_TERM = 8,
  parameter  int N_OUT  = 4,
  parameter  int DLY_W  = 3,
  parameter  int IDX_W  = 3,
  localparam int ADDR_W = IDX_W + 2,
  localparam int DATA_W = 2 * N_IN
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [N_IN-1:0][DLY_W-1:0]       dly_o,
  output logic [N_TERM-1:0][DATA_W-1:0]    term_o,
  output logic [N_OUT-1:0][N_TERM-1:0]     or_o
);
  import cdet_pkg::*;

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic [N_IN-1:0][DLY_W-1:0]    dly_q;
  logic [N_TERM-1:0][DATA_W-1:0] term_q;
  logic [N_OUT-1:0][N_TERM-1:0]  or_q;

  assign region = addr_i[ADDR_W-1 -: 2];
  assign idx    = addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q  <= '0;
      term_q <= '0;
      or_q   <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N_IN; i++)
        if (region == RG_DLY && int'(idx) == i) dly_q[i] <= wdata_i[DLY_W-1:0];
      for (int j = 0; j < N_TERM; j++)
        if (region == RG_TERM && int'(idx) == j) term_q[j] <= wdata_i;
      for (int o = 0; o < N_OUT; o++)
        if (region == RG_OR && int'(idx) == o) or_q[o] <= wdata_i[N_TERM-1:0];
    end
  end

  assign dly_o  = dly_q;
  assign term_o = term_q;
  assign or_o   = or_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(dly_q) && $stable(term_q) && $stable(or_q))); // R8

  for (genvar i = 0; i < N_IN; i++) begin : g_dly_chk
    AST_DLY_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && region == RG_DLY && int'(idx) == i) |=> dly_q[i] == $past(wdata_i[DLY_W-1:0])); // R7
  end

  AST_NONE_REGION_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && region == RG_NONE) |=> ($stable(dly_q) && $stable(term_q) && $stable(or_q))); // R7
endmodule

// File: rtl/cdet_dly.sv
module cdet_dly #(
  parameter int DLY_MAX = 6,
  parameter int DLY_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             out_o
);
  logic [DLY_MAX-1:0] st_q;
  logic [DLY_W-1:0]   sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else begin
      st_q[0] <= in_i;
      for (int k = 1; k < DLY_MAX; k++) st_q[k] <= st_q[k-1];
    end
  end

  // out-of-range settings saturate at the deepest tap
  assign sel = (int'(dly_i) > DLY_MAX) ? DLY_W'(DLY_MAX) : dly_i;

  always_comb begin
    out_o = in_i;
    for (int k = 1; k <= DLY_MAX; k++)
      if (int'(sel) == k) out_o = st_q[k-1];
  end
endmodule

// File: rtl/cdet_pla.sv
module cdet_pla #(
  parameter  int N_IN   = 8,
  parameter  int N_TERM = 8,
  parameter  int N_OUT  = 4,
  localparam int DATA_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]                  x_i,
  input  logic [N_TERM-1:0][DATA_W-1:0]    term_i,
  input  logic [N_OUT-1:0][N_TERM-1:0]     or_i,
  output logic [N_TERM-1:0]                hit_o,
  output logic [N_OUT-1:0]                 cond_o
);
  for (genvar j = 0; j < N_TERM; j++) begin : g_term
    logic [N_IN-1:0] t_en, c_en;
    assign t_en = term_i[j][N_IN-1:0];
    assign c_en = term_i[j][DATA_W-1:N_IN];
    // an empty term is forced low so it never fires
    assign hit_o[j] = (|(t_en | c_en)) && ((t_en & ~x_i) == '0) && ((c_en & x_i) == '0);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_or
    assign cond_o[o] = |(or_i[o] & hit_o);
  end
endmodule

// File: rtl/cond_detect.sv
module cond_detect #(
  parameter  int N_IN    = cdet_pkg::N_IN,
  parameter  int DLY_MAX = cdet_pkg::DLY_MAX,
  parameter  int N_TERM  = cdet_pkg::N_TERM,
  parameter  int N_OUT   = cdet_pkg::N_OUT,
  localparam int DLY_W   = $clog2(DLY_MAX + 2),
  localparam int IDX_W   = cdet_pkg::idx_w(N_IN, N_TERM, N_OUT),
  localparam int ADDR_W  = IDX_W + 2,
  localparam int DATA_W  = 2 * N_IN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [N_IN-1:0]   sig_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [N_OUT-1:0]  flag_o
);
  logic [N_IN-1:0][DLY_W-1:0]    dly;
  logic [N_TERM-1:0][DATA_W-1:0] term;
  logic [N_OUT-1:0][N_TERM-1:0]  orm;
  logic [N_IN-1:0]               aligned;
  logic [N_TERM-1:0]             hit;
  logic [N_OUT-1:0]              cond;
  logic [N_OUT-1:0]              flag_q;

  cdet_cfg #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .DLY_W(DLY_W), .IDX_W(IDX_W)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .dly_o(dly), .term_o(term), .or_o(orm)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_dly
    cdet_dly #(.DLY_MAX(DLY_MAX), .DLY_W(DLY_W)) i_dly (
      .clk_i, .rst_ni, .in_i(sig_i[i]), .dly_i(dly[i]), .out_o(aligned[i])
    );
  end

  cdet_pla #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) i_pla (
    .x_i(aligned), .term_i(term), .or_i(orm), .hit_o(hit), .cond_o(cond)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= en_i ? cond : '0;
  end

  assign flag_o = flag_q;

  AST_FLAG_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> flag_o == '0); // R9

  for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
    AST_FLAG_NEEDS_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[o] |-> $past(orm[o] != '0)); // R6
  end

  for (genvar j = 0; j < N_TERM; j++) begin : g_term_chk
    AST_EMPTY_TERM_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (term[j] == '0) |-> !hit[j]); // R5
  end
endmodule

// File: tb/test_cond_detect.sv
`timescale 1ns/1ps
module test_cond_detect;
  localparam int NI = 8;
  localparam int NT = 8;
  localparam int NO = 4;
  localparam int DM = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [NI-1:0] sig = '0;
  logic          we = 1'b0;
  logic [4:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [NO-1:0] flag;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [NI-1:0] h [0:DM];
  int            dly_m [NI];
  logic [15:0]   tm_m [NT];
  logic [NT-1:0] om_m [NO];
  logic [31:0]   lf = 32'h1234_5678;

  always #2.5 clk = ~clk;

  cond_detect i_cond_detect (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sig_i(sig),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .flag_o(flag)
  );

  function automatic logic [31:0] nxt(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  function automatic logic [NO-1:0] model(input logic en_v);
    logic [NI-1:0] a, t, c;
    logic [NT-1:0] hit;
    logic [NO-1:0] r;
    for (int i = 0; i < NI; i++) begin
      int d;
      d = (dly_m[i] > DM) ? DM : dly_m[i];
      a[i] = h[d][i];
    end
    for (int j = 0; j < NT; j++) begin
      t = tm_m[j][NI-1:0];
      c = tm_m[j][15:NI];
      hit[j] = (|(t | c)) && ((t & ~a) == '0) && ((c & a) == '0);
    end
    for (int o = 0; o < NO; o++) r[o] = |(om_m[o] & hit);
    return en_v ? r : '0;
  endfunction

  task automatic chk(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s flag=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [NI-1:0] s);
    for (int k = DM; k > 0; k--) h[k] = h[k-1];
    h[0] = s;
  endtask

  task automatic step(input logic [NI-1:0] s, input string req);
    logic [NO-1:0] exp;
    sig = s;
    push(s);
    exp = model(en);
    @(negedge clk);
    chk(req, flag, exp);
  endtask

  task automatic mirror(input logic [4:0] a, input logic [15:0] d);
    int idx;
    idx = int'(a[2:0]);
    case (a[4:3])
      2'd0: if (idx < NI) dly_m[idx] = int'(d[2:0]);
      2'd1: if (idx < NT) tm_m[idx] = d;
      2'd2: if (idx < NO) om_m[idx] = d[NT-1:0];
      default: ;
    endcase
  endtask

  task automatic cfg_wr(input logic [1:0] rg, input logic [2:0] idx, input logic [15:0] d);
    sig = '0;
    push('0);
    we = 1'b1;
    addr = {rg, idx};
    wdata = d;
    @(negedge clk);
    we = 1'b0;
    mirror({rg, idx}, d);
  endtask

  task automatic flush(input int n, input string req);
    for (int k = 0; k < n; k++) step('0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k <= DM; k++) h[k] = '0;
    for (int i = 0; i < NI; i++) dly_m[i] = 0;
    for (int j = 0; j < NT; j++) tm_m[j] = '0;
    for (int o = 0; o < NO; o++) om_m[o] = '0;

    @(negedge clk);
    @(negedge clk);
    chk("R1 reset", flag, '0);
    rst_n = 1'b1;
    en = 1'b1;
    // R1: zero settings never fire
    for (int s = 0; s < 256; s += 17) step(NI'(s), "R1");

    // R2/R3: pulse on each input through each delay tap
    for (int i = 0; i < NI; i++) begin
      for (int d = 0; d <= 7; d++) begin
        cfg_wr(2'd1, 3'd0, 16'(1 << i));
        cfg_wr(2'd2, 3'd0, 16'h0001);
        cfg_wr(2'd0, 3'(i), 16'(d));
        flush(7, (d > DM) ? "R3" : "R2");
        step(NI'(1 << i), (d > DM) ? "R3" : "R2");
        flush(8, (d > DM) ? "R3" : "R2");
      end
      cfg_wr(2'd0, 3'(i), 16'd0);
    end
    cfg_wr(2'd1, 3'd0, 16'd0);
    flush(2, "R2");

    // R4: three-literal term, exhaustive
    cfg_wr(2'd1, 3'd0, 16'((1 << 0) | (1 << 5) | (1 << (8 + 3))));
    cfg_wr(2'd2, 3'd0, 16'h0001);
    // R5: empty term and contradictory term routed to outputs 1 and 2
    cfg_wr(2'd1, 3'd1, 16'h0000);
    cfg_wr(2'd2, 3'd1, 16'h0002);
    cfg_wr(2'd1, 3'd2, 16'((1 << 2) | (1 << (8 + 2))));
    cfg_wr(2'd2, 3'd2, 16'h0004);
    flush(1, "R4");
    for (int s = 0; s < 256; s++) begin
      step(NI'(s), "R4");
      if (flag[2:1] !== 2'b00) begin
        checks++; errs++;
        $display("FAIL R5 flag=%b expected=%b", flag, 4'b0000);
      end else checks++;
    end

    // R6/R10: two terms ORed into output 3, term 3 shared with output 0
    cfg_wr(2'd1, 3'd3, 16'h0002);
    cfg_wr(2'd1, 3'd4, 16'h0040);
    cfg_wr(2'd2, 3'd3, 16'h0018);
    cfg_wr(2'd2, 3'd0, 16'h0009);
    flush(1, "R6");
    for (int s = 0; s < 256; s++) step(NI'(s), "R6");
    step(8'h02, "R10");
    chk("R10 shared term", flag, 4'b1001);

    // R7: writes to region 3 and out-of-range OR index change nothing
    cfg_wr(2'd3, 3'd0, 16'hFFFF);
    cfg_wr(2'd3, 3'd3, 16'hFFFF);
    cfg_wr(2'd2, 3'd5, 16'h00FF);
    cfg_wr(2'd2, 3'd7, 16'h00FF);
    flush(1, "R7");
    for (int s = 0; s < 256; s++) step(NI'(s), "R7");

    // R2: random delays and sparse terms
    for (int round = 0; round < 6; round++) begin
      for (int i = 0; i < NI; i++) begin
        lf = nxt(lf);
        cfg_wr(2'd0, 3'(i), {13'd0, lf[2:0]});
      end
      for (int j = 0; j < NT; j++) begin
        lf = nxt(lf);
        cfg_wr(2'd1, 3'(j), lf[15:0] & nxt(lf)[15:0] & nxt(nxt(lf))[15:0]);
      end
      for (int o = 0; o < NO; o++) begin
        lf = nxt(lf);
        cfg_wr(2'd2, 3'(o), {8'd0, lf[7:0]});
      end
      for (int k = 0; k < 120; k++) begin
        lf = nxt(lf);
        step(lf[NI-1:0], "R2");
      end
    end

    // R9: disable gates flags; delay lines keep running
    en = 1'b0;
    for (int k = 0; k < 40; k++) begin
      lf = nxt(lf);
      step(lf[NI-1:0], "R9");
    end
    en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      lf = nxt(lf);
      step(lf[NI-1:0], "R9");
    end

    // R8: write lands one cycle later
    for (int i = 0; i < NI; i++) cfg_wr(2'd0, 3'(i), 16'd0);
    for (int o = 0; o < NO; o++) cfg_wr(2'd2, 3'(o), 16'd0);
    cfg_wr(2'd1, 3'd0, 16'h0001);
    flush(1, "R8");
    begin
      logic [NO-1:0] exp;
      sig = 8'h01;
      push(8'h01);
      we = 1'b1;
      addr = {2'd2, 3'd0};
      wdata = 16'h0001;
      exp = model(en);
      @(negedge clk);
      we = 1'b0;
      chk("R8 old setting in write cycle", flag, exp);
      mirror({2'd2, 3'd0}, 16'h0001);
      step(8'h01, "R8");
      chk("R8 new setting", flag, 4'b0001);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule